// File: doc/BRIEF.md
# Planar Video Memory Host Access Path

This block sits between a host byte port and a flat video memory that is organised as a stack of planes, each plane a fixed stride above the previous one. A host read fetches the same offset from every plane at once. It loads the first four of those bytes into per-plane latches and returns one byte one cycle later. A host write is spread over the planes selected by a map mask. Each plane receives either the raw host byte or a value combined from the host byte and that plane's latch.

Mode inputs change the shape of an access. An eight-plane mode widens a write from four planes to eight and can compress the address by eight. An address-doubling mode turns a four-plane write into a pair of consecutive bytes per plane. A linear mode sends a write to a single byte with no plane split. A small mode register holds the write mode and the read mode, and its write-mode field is either two or three bits wide. Every memory address wraps at the memory size.

Top module: `planar_vmem_path`

## Requirements
- R1: After reset, rd_valid_o is 0, rd_data_o is 0x00 and mode_rdata_o is 0x00.
- R2: A host read cycle (host_rd_i high at a clock edge) makes rd_valid_o high for exactly the next cycle, and rd_data_o changes only after a read cycle and holds its value otherwise.
- R3: The read byte is the byte at A when linear_i is 1 or the read-mode bit is 1. Otherwise it is the OR of the bytes at A + i*STRIDE over planes i whose map_mask_i bit is set, with i limited to 0..3, or to 0..7 when eight_plane_i is 1.
- R4: A read with host_peek_i low loads latch k (k = 0..3) from A + k*STRIDE. A read with host_peek_i high leaves all latches unchanged.
- R5: With linear_i 1 and eight_plane_i 0, a write stores the raw host byte at A only, whatever the combine and mode settings.
- R6: With eight_plane_i 1, plane i (0..7) whose mask bit is set receives one byte at B + i*STRIDE, where B is A>>3 if addr_scale_i is 1 and A otherwise. This path takes priority over linear_i.
- R7: In the four-plane path (eight_plane_i 0, linear_i 0), mask bits 7..4 are ignored. Plane i (0..3) whose mask bit is set receives the byte at A + i*STRIDE, or, with addr_scale_i 1, the two bytes at 2A + i*STRIDE and 2A + i*STRIDE + 1.
- R8: In the plane paths, with combine_i 1, plane i receives a value built from host byte D, latch L = latch[i mod 4] and the effective write mode W. W = 4..7 gives D xor L. W = 0 gives D, W = 1 gives L, W = 2 gives all bits set to D[i], and W = 3 gives D and L. With combine_i 0 the plane receives D.
- R9: The mode register has the write mode in bits 2:0 and the read mode in bit 3. A write stores data bits 2:0 when wide_wm_i is 1, and bits 1:0 with bit 2 cleared when it is 0. The effective write mode and the readback of bits 2:0 are the stored value with bit 2 masked off while wide_wm_i is 0. Readback bits 7:4 are 0.
- R10: All read and write addresses, including doubled and plane-offset ones, wrap modulo the memory size (2048 bytes, STRIDE 256 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Write strobe for the mode register |
| mode_wdata_i | input | 8 | Mode register write data |
| mode_rdata_o | output | 8 | Mode register readback |
| wide_wm_i | input | 1 | Three-bit write-mode field when 1 |
| eight_plane_i | input | 1 | Eight-plane write path |
| addr_scale_i | input | 1 | Address compression (eight-plane) or doubling (four-plane) |
| linear_i | input | 1 | Linear single-byte access |
| combine_i | input | 1 | Latch-combined write data |
| map_mask_i | input | NUM_PLANES | Plane enable mask |
| host_rd_i | input | 1 | Host read strobe |
| host_peek_i | input | 1 | Read without latch load |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | MEM_AW | Host byte address A |
| host_wdata_i | input | 8 | Host write byte D |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 8 | Registered read data |

## Verification
The checker assumes the host never raises host_rd_i and host_wr_i in the same cycle, and it flags any cycle that does. The read-timing and mode-register properties rely on that. The stimulus issues one access per task, holds every strobe for exactly one cycle and changes the mode inputs only between accesses. Expected memory contents come from a bench model, and a full linear scan with latch-preserving reads compares every byte against that model.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

  typedef logic [7:0] byte_t;

  // plane value under the latch-combine function; pidx selects the host bit for mode 2
  function automatic byte_t combine_byte(input logic [2:0] wm, input byte_t d,
                                         input byte_t lat, input logic [2:0] pidx);
    byte_t r;
    if (wm[2]) begin
      r = d ^ lat;
    end else begin
      case (wm[1:0])
        2'd0:    r = d;
        2'd1:    r = lat;
        2'd2:    r = {8{d[pidx]}};
        default: r = d & lat;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/vmem_mode_reg.sv
module vmem_mode_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       wide_i,
  output logic [2:0] wm_o,
  output logic       rd_mode_o,
  output logic [7:0] rdata_o
);

  logic [2:0] wm_q;
  logic       rm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm_q <= 3'd0;
      rm_q <= 1'b0;
    end else if (we_i) begin
      wm_q <= {wide_i & wdata_i[2], wdata_i[1:0]};
      rm_q <= wdata_i[3];
    end
  end

  // narrow field hides a stale bit 2 both for use and readback
  assign wm_o      = {wide_i & wm_q[2], wm_q[1:0]};
  assign rd_mode_o = rm_q;
  assign rdata_o   = {4'h0, rm_q, wm_o};

endmodule

// File: rtl/vmem_array.sv
module vmem_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned NW = 16,
  parameter int unsigned NR = 8
) (
  input  logic                   clk_i,
  input  logic [NW-1:0]          we_i,
  input  logic [NW-1:0][AW-1:0]  waddr_i,
  input  logic [NW-1:0][7:0]     wdata_i,
  input  logic [NR-1:0][AW-1:0]  raddr_i,
  output logic [NR-1:0][7:0]     rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];

  // higher port index wins on an address clash
  always_ff @(posedge clk_i) begin
    for (int unsigned k = 0; k < NW; k++) begin
      if (we_i[k]) mem_q[waddr_i[k]] <= wdata_i[k];
    end
  end

  for (genvar r = 0; r < NR; r++) begin : g_rd
    assign rdata_o[r] = mem_q[raddr_i[r]];
  end

endmodule

// File: rtl/vmem_wr_decode.sv
module vmem_wr_decode
  import vmem_pkg::*;
#(
  parameter int unsigned AW          = 11,
  parameter int unsigned PLANE_SHIFT = 8,
  parameter int unsigned NUM_PLANES  = 8,
  parameter int unsigned BASE_PLANES = 4
) (
  input  logic                                 wr_i,
  input  logic [AW-1:0]                        addr_i,
  input  byte_t                                data_i,
  input  logic                                 eight_i,
  input  logic                                 scale_i,
  input  logic                                 linear_i,
  input  logic                                 combine_i,
  input  logic [NUM_PLANES-1:0]                mask_i,
  input  logic [2:0]                           wm_i,
  input  logic [BASE_PLANES-1:0][7:0]          lat_i,
  output logic [2*NUM_PLANES-1:0]              we_o,
  output logic [2*NUM_PLANES-1:0][AW-1:0]      waddr_o,
  output logic [2*NUM_PLANES-1:0][7:0]         wdata_o
);

  logic [AW-1:0] base;
  logic          pair_mode;
  logic          lin_only;

  assign lin_only  = linear_i & ~eight_i;
  assign pair_mode = ~eight_i & ~linear_i & scale_i;

  always_comb begin
    if (eight_i)       base = scale_i ? (addr_i >> 3) : addr_i;
    else if (linear_i) base = addr_i;
    else               base = scale_i ? (addr_i << 1) : addr_i;
  end

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    localparam logic [AW-1:0] OFS     = AW'(p << PLANE_SHIFT);
    localparam int unsigned   LI      = p % BASE_PLANES;
    localparam bit            IS_BASE = (p < BASE_PLANES);
    localparam bit            IS_P0   = (p == 0);

    logic  sel;
    byte_t val;

    always_comb begin
      if (eight_i)       sel = mask_i[p];
      else if (linear_i) sel = IS_P0;
      else               sel = IS_BASE & mask_i[p];
    end

    assign val = (combine_i & ~lin_only) ? combine_byte(wm_i, data_i, lat_i[LI], 3'(p)) : data_i;

    assign we_o[2*p]        = wr_i & sel;
    assign waddr_o[2*p]     = base + OFS;
    assign wdata_o[2*p]     = val;
    assign we_o[2*p+1]      = wr_i & sel & pair_mode;
    assign waddr_o[2*p+1]   = base + OFS + AW'(1);
    assign wdata_o[2*p+1]   = val;
  end

endmodule

// File: rtl/planar_vmem_path.sv
module planar_vmem_path
  import vmem_pkg::*;
#(
  parameter int unsigned MEM_AW      = 11,
  parameter int unsigned PLANE_SHIFT = 8,
  parameter int unsigned NUM_PLANES  = 8,
  parameter int unsigned BASE_PLANES = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_we_i,
  input  logic [7:0]            mode_wdata_i,
  output logic [7:0]            mode_rdata_o,
  input  logic                  wide_wm_i,
  input  logic                  eight_plane_i,
  input  logic                  addr_scale_i,
  input  logic                  linear_i,
  input  logic                  combine_i,
  input  logic [NUM_PLANES-1:0] map_mask_i,
  input  logic                  host_rd_i,
  input  logic                  host_peek_i,
  input  logic                  host_wr_i,
  input  logic [MEM_AW-1:0]     host_addr_i,
  input  logic [7:0]            host_wdata_i,
  output logic                  rd_valid_o,
  output logic [7:0]            rd_data_o
);

  localparam int unsigned NW = 2 * NUM_PLANES;

  logic [2:0]                       wm_eff;
  logic                             rd_mode;
  logic [BASE_PLANES-1:0][7:0]      lat_q;
  logic [NUM_PLANES-1:0][MEM_AW-1:0] rd_addr;
  logic [NUM_PLANES-1:0][7:0]       rd_bytes;
  logic [NW-1:0]                    wr_en;
  logic [NW-1:0][MEM_AW-1:0]        wr_addr;
  logic [NW-1:0][7:0]               wr_data;
  byte_t                            rd_next;

  vmem_mode_reg u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (mode_we_i),
    .wdata_i  (mode_wdata_i),
    .wide_i   (wide_wm_i),
    .wm_o     (wm_eff),
    .rd_mode_o(rd_mode),
    .rdata_o  (mode_rdata_o)
  );

  vmem_wr_decode #(
    .AW         (MEM_AW),
    .PLANE_SHIFT(PLANE_SHIFT),
    .NUM_PLANES (NUM_PLANES),
    .BASE_PLANES(BASE_PLANES)
  ) u_wdec (
    .wr_i     (host_wr_i),
    .addr_i   (host_addr_i),
    .data_i   (host_wdata_i),
    .eight_i  (eight_plane_i),
    .scale_i  (addr_scale_i),
    .linear_i (linear_i),
    .combine_i(combine_i),
    .mask_i   (map_mask_i),
    .wm_i     (wm_eff),
    .lat_i    (lat_q),
    .we_o     (wr_en),
    .waddr_o  (wr_addr),
    .wdata_o  (wr_data)
  );

  for (genvar r = 0; r < NUM_PLANES; r++) begin : g_raddr
    localparam logic [MEM_AW-1:0] OFS = MEM_AW'(r << PLANE_SHIFT);
    assign rd_addr[r] = host_addr_i + OFS;
  end

  vmem_array #(
    .AW(MEM_AW),
    .NW(NW),
    .NR(NUM_PLANES)
  ) u_mem (
    .clk_i  (clk_i),
    .we_i   (wr_en),
    .waddr_i(wr_addr),
    .wdata_i(wr_data),
    .raddr_i(rd_addr),
    .rdata_o(rd_bytes)
  );

  always_comb begin
    rd_next = '0;
    if (linear_i || rd_mode) begin
      rd_next = rd_bytes[0];
    end else begin
      for (int unsigned i = 0; i < NUM_PLANES; i++) begin
        if (map_mask_i[i] && (eight_plane_i || (i < BASE_PLANES))) rd_next |= rd_bytes[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      lat_q      <= '0;
    end else begin
      rd_valid_o <= host_rd_i;
      if (host_rd_i) begin
        rd_data_o <= rd_next;
        if (!host_peek_i) begin
          for (int unsigned k = 0; k < BASE_PLANES; k++) lat_q[k] <= rd_bytes[k];
        end
      end
    end
  end

endmodule

// File: rtl/vmem_path_chk.sv
module vmem_path_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       host_rd_i,
  input logic       host_wr_i,
  input logic       rd_valid_o,
  input logic [7:0] rd_data_o,
  input logic       mode_we_i,
  input logic [2:0] wm_wdata_i,
  input logic       wide_wm_i,
  input logic [7:0] mode_rdata_o
);

  AST_ONE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_rd_i && host_wr_i)); // R2

  AST_VALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rd_i |=> rd_valid_o); // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> !rd_valid_o); // R2

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rd_i |=> $stable(rd_data_o)); // R2

  AST_WIDE_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && wide_wm_i) |=> (!wide_wm_i || (mode_rdata_o[2:0] == $past(wm_wdata_i)))); // R9

  AST_NARROW_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_we_i && !wide_wm_i) |=> !mode_rdata_o[2]); // R9

  AST_MODE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_we_i |=> ((wide_wm_i != $past(wide_wm_i)) || $stable(mode_rdata_o))); // R9

endmodule

bind planar_vmem_path vmem_path_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_rd_i   (host_rd_i),
  .host_wr_i   (host_wr_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .mode_we_i   (mode_we_i),
  .wm_wdata_i  (mode_wdata_i[2:0]),
  .wide_wm_i   (wide_wm_i),
  .mode_rdata_o(mode_rdata_o)
);

// File: tb/tb_planar_vmem_path.sv
module tb_planar_vmem_path;

  localparam int AW    = 11;
  localparam int DEPTH = 2048;
  localparam int STR   = 256;
  localparam int AM    = DEPTH - 1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_we = 1'b0;
  logic [7:0]    mode_wdata = '0;
  logic [7:0]    mode_rdata;
  logic          wide = 1'b0, eight = 1'b0, scale = 1'b0, lin = 1'b0, comb = 1'b0;
  logic [7:0]    mask = '0;
  logic          host_rd = 1'b0, host_peek = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [7:0]    host_wdata = '0;
  logic          rd_valid;
  logic [7:0]    rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] mm [DEPTH];
  logic [7:0] ml [4];
  logic [2:0] m_wm = '0;
  logic       m_rm = 1'b0;

  always #2 clk = ~clk;

  planar_vmem_path dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .mode_we_i(mode_we), .mode_wdata_i(mode_wdata), .mode_rdata_o(mode_rdata),
    .wide_wm_i(wide), .eight_plane_i(eight), .addr_scale_i(scale), .linear_i(lin),
    .combine_i(comb), .map_mask_i(mask),
    .host_rd_i(host_rd), .host_peek_i(host_peek), .host_wr_i(host_wr),
    .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] eff_wm();
    return wide ? m_wm : {1'b0, m_wm[1:0]};
  endfunction

  function automatic logic [7:0] exp_mode();
    return {4'h0, m_rm, eff_wm()};
  endfunction

  function automatic logic [7:0] m_val(input int i, input logic [7:0] d);
    logic [2:0] w;
    logic [7:0] l;
    if (!comb) return d;
    w = eff_wm();
    l = ml[i % 4];
    if (w >= 3'd4) return d ^ l;
    if (w == 3'd0) return d;
    if (w == 3'd1) return l;
    if (w == 3'd2) return d[i] ? 8'hFF : 8'h00;
    return d & l;
  endfunction

  function automatic logic [7:0] m_read(input int a);
    logic [7:0] r;
    if (lin || m_rm) return mm[a];
    r = '0;
    for (int i = 0; i < 8; i++)
      if (mask[i] && (eight || i < 4)) r |= mm[(a + i * STR) & AM];
    return r;
  endfunction

  task automatic m_write(input int a, input logic [7:0] d);
    int b;
    if (eight) begin
      b = scale ? (a >> 3) : a;
      for (int i = 0; i < 8; i++) if (mask[i]) mm[(b + i * STR) & AM] = m_val(i, d);
    end else if (lin) begin
      mm[a] = d;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (mask[i]) begin
          if (scale) begin
            mm[(2 * a + i * STR) & AM]     = m_val(i, d);
            mm[(2 * a + i * STR + 1) & AM] = m_val(i, d);
          end else begin
            mm[(a + i * STR) & AM] = m_val(i, d);
          end
        end
      end
    end
  endtask

  task automatic op_write(input int a, input logic [7:0] d);
    @(negedge clk);
    host_addr = AW'(a); host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    m_write(a, d);
  endtask

  task automatic op_read(input int a, input bit pk, input string req);
    logic [7:0] e;
    @(negedge clk);
    host_addr = AW'(a); host_peek = pk; host_rd = 1'b1;
    e = m_read(a);
    @(negedge clk);
    host_rd = 1'b0;
    chk(req, {rd_valid, rd_data}, {1'b1, e});
    if (!pk) for (int k = 0; k < 4; k++) ml[k] = mm[(a + k * STR) & AM];
  endtask

  task automatic peek_byte(input int a, input logic [7:0] e, input string req);
    logic sv;
    @(negedge clk);
    sv = lin; lin = 1'b1;
    host_addr = AW'(a); host_peek = 1'b1; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0; lin = sv;
    chk(req, rd_data, e);
  endtask

  task automatic mode_wr(input logic [7:0] d);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = d;
    @(negedge clk);
    mode_we = 1'b0;
    m_wm = wide ? d[2:0] : {1'b0, d[1:0]};
    m_rm = d[3];
  endtask

  task automatic scan(input string req);
    for (int a = 0; a < DEPTH; a++) peek_byte(a, mm[a], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1", {rd_valid, rd_data, mode_rdata}, {1'b0, 8'h00, 8'h00});
    rst_ni = 1'b1;

    // fill memory through the linear path
    lin = 1'b1;
    for (int a = 0; a < DEPTH; a++) op_write(a, 8'(a * 37 + 5));

    // R5 linear write hits one byte only
    comb = 1'b1;
    op_write(12'h555, 8'h3C);
    peek_byte(12'h555, 8'h3C, "R5");
    peek_byte(12'h556, mm[12'h556], "R5");
    peek_byte(12'h455, mm[12'h455], "R5");
    comb = 1'b0;

    // R9 mode register width handling
    wide = 1'b1; mode_wr(8'h0D);
    @(negedge clk); chk("R9", mode_rdata, 8'h0D);
    wide = 1'b0;
    @(negedge clk); chk("R9", mode_rdata, 8'h09);
    mode_wr(8'h0E);
    @(negedge clk); chk("R9", mode_rdata, 8'h0A);
    wide = 1'b1;
    @(negedge clk); chk("R9", mode_rdata, 8'h0A);
    mode_wr(8'h00);

    // R3 planar reads: byte at 0x010 + k*256 is 1<<k
    for (int k = 0; k < 8; k++) op_write(12'h010 + k * STR, 8'(1 << k));
    lin = 1'b0; mask = 8'hFF;
    op_read(12'h010, 1'b0, "R3");
    chk("R3", rd_data, 8'h0F);
    eight = 1'b1;
    op_read(12'h010, 1'b1, "R3");
    chk("R3", rd_data, 8'hFF);
    mask = 8'hF0;
    op_read(12'h010, 1'b1, "R3");
    chk("R3", rd_data, 8'hF0);
    eight = 1'b0;
    op_read(12'h010, 1'b1, "R7");
    chk("R7", rd_data, 8'h00);
    @(negedge clk);
    chk("R2", {rd_valid, rd_data}, {1'b0, 8'h00});
    mode_wr(8'h08);
    op_read(12'h010, 1'b1, "R3");
    chk("R3", rd_data, 8'h01);
    mode_wr(8'h00);

    // R4 peek keeps latches 01,02,04,08; R8 latch copy mode
    mask = 8'h0F;
    op_read(12'h300, 1'b1, "R4");
    comb = 1'b1; mode_wr(8'h01);
    op_write(12'h020, 8'hAA);
    peek_byte(12'h120, 8'h02, "R4");
    peek_byte(12'h320, 8'h08, "R4");
    mode_wr(8'h02);
    op_write(12'h021, 8'h06);
    peek_byte(12'h021, 8'h00, "R8");
    peek_byte(12'h121, 8'hFF, "R8");
    peek_byte(12'h221, 8'hFF, "R8");
    mode_wr(8'h05);
    op_write(12'h022, 8'hF0);
    peek_byte(12'h222, 8'hF4, "R8");
    mode_wr(8'h03);
    op_write(12'h023, 8'h0E);
    peek_byte(12'h123, 8'h02, "R8");
    peek_byte(12'h023, 8'h00, "R8");
    comb = 1'b0; mode_wr(8'h05);
    op_write(12'h024, 8'h77);
    peek_byte(12'h324, 8'h77, "R8");
    comb = 1'b1; eight = 1'b1; mask = 8'h30; mode_wr(8'h01);
    op_write(12'h030, 8'h99);
    peek_byte(12'h430, 8'h01, "R8");
    peek_byte(12'h530, 8'h02, "R8");
    comb = 1'b0;

    // R6 eight-plane compressed address with wrap, priority over linear
    scale = 1'b1; mask = 8'h81;
    op_write(12'h7FF, 8'hC3);
    peek_byte(12'h0FF, 8'hC3, "R6");
    peek_byte(12'h7FF, 8'hC3, "R6");
    peek_byte(12'h1FF, mm[12'h1FF], "R6");
    scale = 1'b0; lin = 1'b1; mask = 8'h04;
    op_write(12'h033, 8'h5D);
    peek_byte(12'h233, 8'h5D, "R6");
    peek_byte(12'h033, mm[12'h033], "R6");
    lin = 1'b0; eight = 1'b0;

    // R7/R10 doubled address wraps past the top
    scale = 1'b1; mask = 8'h03;
    op_write(12'h403, 8'h5A);
    peek_byte(12'h006, 8'h5A, "R10");
    peek_byte(12'h007, 8'h5A, "R10");
    peek_byte(12'h107, 8'h5A, "R7");
    peek_byte(12'h206, mm[12'h206], "R7");
    scale = 1'b0; mask = 8'hF0;
    op_write(12'h066, 8'hE1);
    peek_byte(12'h066, mm[12'h066], "R7");
    peek_byte(12'h466, mm[12'h466], "R7");
    mask = 8'h0F;
    op_read(12'h7F0, 1'b0, "R10");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int op;
      lin   = ($urandom % 4) == 0;
      eight = ($urandom % 3) == 0;
      scale = 1'($urandom);
      wide  = 1'($urandom);
      comb  = 1'($urandom);
      mask  = 8'($urandom);
      op = $urandom % 10;
      if (op < 4)       op_write($urandom % DEPTH, 8'($urandom));
      else if (op < 8)  op_read($urandom % DEPTH, 1'($urandom), "R3");
      else if (op == 8) mode_wr(8'($urandom));
      else begin
        @(negedge clk);
        chk("R9", mode_rdata, exp_mode());
      end
    end
    lin = 1'b0; eight = 1'b0; scale = 1'b0; comb = 1'b0;
    scan("R6");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule